// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Controller

This block sits between an on-chip requester and an external asynchronous static RAM of 524,288 sixteen-bit words. The requester offers one operation at a time over a valid/ready handshake: a 19-bit word address, a read/write flag, write data and two byte-lane enables. The controller turns each operation into a correctly timed strobe sequence on the memory pins. For a read it returns the captured word with a one-cycle valid pulse.

The memory has no clock, so every interval it needs is counted in controller clock cycles. There are four counts: the read window, the write strobe width, the data setup ahead of the end of the write strobe, and the whole write cycle. A fifth count sets the quiet gap that must pass after output enable rises before the controller drives the shared data pins. The data bus is split into an output word, an input word and a drive enable, so the tri-state pad can be placed outside the block.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high and in the first idle cycle after it, `req_ready` is 1. The chip is deselected (`mem_cs1_n`=1, `mem_cs2`=0). Both lane enables, `mem_oe_n` and `mem_we_n` are 1, and `mem_dq_oe` and `rsp_valid` are 0.
- R2: The memory counts as selected only when `mem_cs1_n`=0 and `mem_cs2`=1. This holds in every cycle of an operation. In every idle cycle both selects are inactive.
- R3: During an operation, `req_lanes` bit 0 drives `mem_lb_n` (data bits 7..0) and bit 1 drives `mem_ub_n` (data bits 15..8), both active low. No lane enable is ever low while the chip is deselected.
- R4: A read holds `mem_oe_n` low, with `mem_we_n` high, for exactly RD_CYC consecutive cycles. The chip stays selected for exactly those cycles. The word present in the last cycle appears on `rsp_data`, with `rsp_valid` high for exactly the following cycle.
- R5: On a read, any data lane whose `req_lanes` bit is 0 returns zero in `rsp_data`, whatever the memory pins carry.
- R6: A write holds `mem_we_n` low for exactly max(WR_PULSE, WR_SETUP) consecutive cycles. `mem_oe_n` stays high throughout, and `mem_dq_out` is stable for the whole strobe.
- R7: A write keeps the chip selected for at least WR_CYC cycles. Only the lanes whose `req_lanes` bit is 1 change in memory, so a later read returns the other lanes unchanged.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low. It rises only after `mem_oe_n` has been high for at least TURN cycles.
- R9: `mem_dq_oe` is still high in the cycle `mem_we_n` rises and is low in the cycle after.
- R10: `req_ready` drops in the cycle after an operation is accepted and stays low until the operation's last strobe cycle has passed.
- R11: `mem_addr` holds the accepted address, unchanged, in every cycle of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle; a request is taken when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Lane enables, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_data | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address pins |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 16 | Data driven toward the pad |
| mem_dq_in | input | 16 | Data received from the pad |
| mem_dq_oe | output | 1 | Pad drive enable |

## Verification
The embedded properties assume that reset is applied before the first request. They also assume every timing count is at least one, and the pulse-length and read-window counters depend on that. The bench keeps within these limits: it holds reset for three cycles, uses the default counts, and raises `req_valid` only between clock edges and only for a single accepted operation. Random traffic uses a small set of addresses at both ends of the range, so reads often hit earlier partial-lane writes. The memory model drives junk on disabled lanes and before the read window ends, which exposes an early capture or a missing lane mask.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WR_TURN,
        ST_WR_PULSE,
        ST_WR_REL
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LANES-1:0]  lanes;
        logic              write;
    } mem_op_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] en);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*8 +: 8] = {8{en[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_turn.sv
module sram_lane_turn #(
    parameter int TURN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic oe_n_i,
    output logic ok_o
);
    localparam int TW = $clog2(TURN + 1);

    logic [TW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= '0;
        end else if (!oe_n_i) begin
            quiet_q <= '0;
        end else if (quiet_q != TW'(TURN)) begin
            quiet_q <= quiet_q + TW'(1);
        end
    end

    assign ok_o = (quiet_q == TW'(TURN)) && oe_n_i;

    // R8: the bus is declared free only after output enable was already high
    a_r8_ok_needs_quiet: assert property (@(posedge clk) disable iff (rst)
        ok_o |-> $past(oe_n_i));

endmodule

// File: rtl/sram_lane_rdcap.sv
module sram_lane_rdcap
    import sram_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_i,
    input  logic [LANES-1:0]  lanes_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              rsp_valid_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_data_o  <= '0;
            rsp_valid_o <= 1'b0;
        end else begin
            rsp_valid_o <= cap_i;
            if (cap_i) begin
                rsp_data_o <= dq_i & lane_mask(lanes_i);
            end
        end
    end

    // R4: read data is announced for a single cycle
    a_r4_one_shot: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int RD_CYC   = 7,
    parameter int WR_PULSE = 5,
    parameter int WR_SETUP = 3,
    parameter int WR_CYC   = 7,
    parameter int TURN     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_lanes,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int PULSE_EFF = int'(max2(WR_PULSE, WR_SETUP));
    localparam int REC_CYC   = (WR_CYC > PULSE_EFF) ? (WR_CYC - PULSE_EFF) : 1;
    localparam int MAX_CNT   = int'(max2(RD_CYC, max2(PULSE_EFF, REC_CYC)));
    localparam int CNT_W     = $clog2(MAX_CNT + 1);

    seq_state_e       state_q;
    mem_op_t          op_q;
    logic             rel_first_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             turn_ok;
    logic             active;
    logic             cap;

    sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    sram_lane_turn #(.TURN(TURN)) u_turn (
        .clk    (clk),
        .rst    (rst),
        .oe_n_i (mem_oe_n),
        .ok_o   (turn_ok)
    );

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                tmr_load = req_valid && !req_write;
                tmr_val  = CNT_W'(RD_CYC);
            end
            ST_WR_TURN: begin
                tmr_load = turn_ok;
                tmr_val  = CNT_W'(PULSE_EFF);
            end
            ST_WR_PULSE: begin
                tmr_load = tmr_done;
                tmr_val  = CNT_W'(REC_CYC);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            op_q        <= '0;
            rel_first_q <= 1'b0;
        end else begin
            rel_first_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q    <= '{addr: req_addr, wdata: req_wdata,
                                 lanes: req_lanes, write: req_write};
                    state_q <= req_write ? ST_WR_TURN : ST_READ;
                end
                ST_READ:     if (tmr_done) state_q <= ST_IDLE;
                ST_WR_TURN:  if (turn_ok)  state_q <= ST_WR_PULSE;
                ST_WR_PULSE: if (tmr_done) begin
                    state_q     <= ST_WR_REL;
                    rel_first_q <= 1'b1;
                end
                ST_WR_REL:   if (tmr_done) state_q <= ST_IDLE;
                default:     state_q <= ST_IDLE;
            endcase
        end
    end

    assign active     = (state_q != ST_IDLE);
    assign req_ready  = !active;
    assign mem_addr   = op_q.addr;
    assign mem_cs1_n  = !active;
    assign mem_cs2    = active;
    assign mem_lb_n   = !(active && op_q.lanes[0]);
    assign mem_ub_n   = !(active && op_q.lanes[1]);
    assign mem_oe_n   = (state_q != ST_READ);
    assign mem_we_n   = (state_q != ST_WR_PULSE);
    assign mem_dq_out = op_q.wdata;
    assign mem_dq_oe  = (state_q == ST_WR_PULSE) || (state_q == ST_WR_REL && rel_first_q);
    assign cap        = (state_q == ST_READ) && tmr_done;

    sram_lane_rdcap u_rdcap (
        .clk         (clk),
        .rst         (rst),
        .cap_i       (cap),
        .lanes_i     (op_q.lanes),
        .dq_i        (mem_dq_in),
        .rsp_data_o  (rsp_data),
        .rsp_valid_o (rsp_valid)
    );

    // Strobe length counters used only by the properties below
    logic [CNT_W-1:0] we_lo_q;
    logic [CNT_W-1:0] oe_lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo_q <= '0;
            oe_lo_q <= '0;
        end else begin
            if (mem_we_n) we_lo_q <= '0;
            else if (we_lo_q != '1) we_lo_q <= we_lo_q + CNT_W'(1);
            if (mem_oe_n) oe_lo_q <= '0;
            else if (oe_lo_q != '1) oe_lo_q <= oe_lo_q + CNT_W'(1);
        end
    end

    a_r6_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_lo_q == CNT_W'(PULSE_EFF)));

    a_r4_read_len: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (oe_lo_q == CNT_W'(RD_CYC)));

    a_r6_data_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

    a_r8_no_fight: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    a_r8_turn_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> turn_ok);

    a_r9_hold_at_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_dq_oe);

    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |=> !mem_dq_oe);

    a_r3_lane_needs_cs: assert property (@(posedge clk) disable iff (rst)
        (!mem_lb_n || !mem_ub_n) |-> (!mem_cs1_n && mem_cs2));

    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r11_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;

    localparam int RD_CYC    = 7;
    localparam int WR_PULSE  = 5;
    localparam int WR_SETUP  = 3;
    localparam int WR_CYC    = 7;
    localparam int TURN      = 3;
    localparam int PULSE_EXP = (WR_PULSE > WR_SETUP) ? WR_PULSE : WR_SETUP;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [18:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_lb_n, mem_ub_n, mem_oe_n, mem_we_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hC3C3;
    logic        mem_dq_oe;

    always #5 clk = ~clk;

    sram_lane_ctrl #(
        .RD_CYC(RD_CYC), .WR_PULSE(WR_PULSE), .WR_SETUP(WR_SETUP),
        .WR_CYC(WR_CYC), .TURN(TURN)
    ) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    logic [15:0] model_mem [logic [18:0]];
    logic [15:0] exp_mem   [logic [18:0]];

    function automatic logic [15:0] lane_bits(input logic [1:0] en);
        return {{8{en[1]}}, {8{en[0]}}};
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] old_w,
                                          input logic [15:0] new_w,
                                          input logic [1:0] en);
        return (old_w & ~lane_bits(en)) | (new_w & lane_bits(en));
    endfunction

    function automatic logic [15:0] model_rd(input logic [18:0] a);
        return model_mem.exists(a) ? model_mem[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [18:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
    endfunction

    // Behavioural memory: byte-lane writes, data valid only late in the read window
    int rd_cnt = 0;
    always @(negedge clk) begin
        logic sel;
        logic [1:0] en;
        logic [15:0] wd;
        logic [15:0] word;
        sel = !mem_cs1_n && mem_cs2;
        en  = {!mem_ub_n, !mem_lb_n};
        if (sel && !mem_we_n) begin
            wd = mem_dq_oe ? mem_dq_out : 16'hBAD0;
            model_mem[mem_addr] = merge(model_rd(mem_addr), wd, en);
        end
        if (sel && !mem_oe_n && mem_we_n) begin
            word = (rd_cnt >= RD_CYC - 1) ? model_rd(mem_addr) : 16'h5A5A;
            mem_dq_in = (word & lane_bits(en)) | (16'hA5A5 & ~lane_bits(en));
            rd_cnt++;
        end else begin
            rd_cnt = 0;
            mem_dq_in = 16'hC3C3;
        end
    end

    // Pin-level monitor: strobe widths, turnaround, contention
    int   we_run = 0, oe_run = 0, oe_hi_run = 100;
    logic p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0, rel_pend = 1'b0;
    logic [15:0] p_dq = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we_n && !p_we) begin
                check(we_run == PULSE_EXP, "R6 write strobe width", 32'(we_run), 32'(PULSE_EXP));
                check(mem_dq_oe, "R9 drive held at strobe end", 32'(mem_dq_oe), 32'd1);
                rel_pend = 1'b1;
            end else if (rel_pend) begin
                check(!mem_dq_oe, "R9 drive released", 32'(mem_dq_oe), 32'd0);
                rel_pend = 1'b0;
            end
            if (!mem_we_n) begin
                check(mem_oe_n, "R6 oe high during write", 32'(mem_oe_n), 32'd1);
                if (!p_we) check(mem_dq_out == p_dq, "R6 data stable", 32'(mem_dq_out), 32'(p_dq));
            end
            if (mem_oe_n && !p_oe)
                check(oe_run == RD_CYC, "R4 read window", 32'(oe_run), 32'(RD_CYC));
            if (mem_dq_oe)
                check(mem_oe_n, "R8 contention", 32'(mem_oe_n), 32'd1);
            if (mem_dq_oe && !p_dqoe)
                check(oe_hi_run >= TURN, "R8 turnaround", 32'(oe_hi_run), 32'(TURN));
        end
        we_run    = !mem_we_n ? we_run + 1 : 0;
        oe_run    = !mem_oe_n ? oe_run + 1 : 0;
        oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
        p_we = mem_we_n; p_oe = mem_oe_n; p_dqoe = mem_dq_oe; p_dq = mem_dq_out;
    end

    task automatic do_op(input bit wr, input logic [18:0] a,
                         input logic [15:0] d, input logic [1:0] en);
        int cs_cyc;
        int guard;
        logic [15:0] expv;
        @(negedge clk);
        guard = 0;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = en;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R10 busy after accept", 32'(req_ready), 32'd0);
        cs_cyc = 0;
        guard  = 0;
        while (!req_ready && guard < 100) begin
            check(!mem_cs1_n && mem_cs2, "R2 selected in op", {mem_cs1_n, mem_cs2}, 32'b01);
            check(mem_lb_n == !en[0] && mem_ub_n == !en[1], "R3 lane map",
                  {mem_ub_n, mem_lb_n}, 32'(~en));
            check(mem_addr == a, "R11 address held", 32'(mem_addr), 32'(a));
            cs_cyc++;
            guard++;
            @(negedge clk);
        end
        check(mem_cs1_n && !mem_cs2, "R2 deselected idle", {mem_cs1_n, mem_cs2}, 32'b10);
        check(mem_lb_n && mem_ub_n, "R3 lanes off idle", {mem_ub_n, mem_lb_n}, 32'b11);
        if (wr) begin
            check(cs_cyc >= WR_CYC, "R7 write cycle length", 32'(cs_cyc), 32'(WR_CYC));
            exp_mem[a] = merge(exp_rd(a), d, en);
        end else begin
            expv = exp_rd(a) & lane_bits(en);
            check(cs_cyc == RD_CYC, "R4 read select span", 32'(cs_cyc), 32'(RD_CYC));
            check(rsp_valid, "R4 response pulse", 32'(rsp_valid), 32'd1);
            check(rsp_data == expv, "R5 R7 read data", 32'(rsp_data), 32'(expv));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready, "R1 ready in reset", 32'(req_ready), 32'd1);
        check(mem_cs1_n && !mem_cs2, "R1 deselected", {mem_cs1_n, mem_cs2}, 32'b10);
        check(mem_lb_n && mem_ub_n, "R1 lanes off", {mem_ub_n, mem_lb_n}, 32'b11);
        check(mem_oe_n && mem_we_n, "R1 strobes off", {mem_oe_n, mem_we_n}, 32'b11);
        check(!mem_dq_oe && !rsp_valid, "R1 no drive no valid", {mem_dq_oe, rsp_valid}, 32'b00);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && mem_cs1_n && !mem_dq_oe, "R1 first idle cycle",
              {req_ready, mem_cs1_n, mem_dq_oe}, 32'b110);

        // directed corners
        do_op(1'b1, 19'h00000, 16'h1234, 2'b11);
        do_op(1'b0, 19'h00000, 16'h0000, 2'b11);   // R4 full read
        do_op(1'b1, 19'h00000, 16'hFFEE, 2'b10);   // R7 upper lane only
        do_op(1'b0, 19'h00000, 16'h0000, 2'b11);
        do_op(1'b1, 19'h00000, 16'h0077, 2'b01);   // R7 lower lane only
        do_op(1'b0, 19'h00000, 16'h0000, 2'b01);   // R5 upper masked
        do_op(1'b0, 19'h00000, 16'h0000, 2'b10);   // R5 lower masked
        do_op(1'b1, 19'h00000, 16'hDEAD, 2'b00);   // R7 no lane written
        do_op(1'b0, 19'h00000, 16'h0000, 2'b11);
        do_op(1'b1, 19'h7FFFF, 16'hCAFE, 2'b11);   // R11 top address
        do_op(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
        do_op(1'b0, 19'h00005, 16'h0000, 2'b11);   // unwritten word

        // constrained random traffic
        void'($urandom(32'd24601));
        for (int i = 0; i < 400; i++) begin
            logic [18:0] a;
            a = ($urandom_range(0, 1) == 1) ? 19'h7FFE0 : 19'h00000;
            a = a | 19'($urandom_range(0, 31));
            do_op(1'($urandom_range(0, 1)), a, 16'($urandom), 2'($urandom_range(0, 3)));
        end

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 32'd1, 32'd0);
        summary();
        $finish;
    end

endmodule